// File: doc/BRIEF.md
# Overlay Color Key Compositor

This block picks, pixel by pixel, whether the overlay plane or the plane beneath it reaches the output. Each clock it takes one overlay pixel and one underlying pixel. Both are 24-bit RGB, made of three 8-bit channels, and each comes with a valid flag. A programmable colour key decides the choice. The key is a per-channel window: a lower bound, an upper bound and a channel-enable mask. A pixel hits the key when every enabled channel lies inside its window.

A configuration write carries a requested keying mode together with new key values. The mode is none, source keying or destination keying. In source keying, overlay pixels that hit the key are punched out and the underlying pixel shows through. In destination keying, the overlay appears only where the underlying pixel hits the key.

Some writes are illegal: a request for both keying kinds at once, or a request for destination keying when the build parameter removes that feature. Such a write is dropped and flagged. The selected pixel and the combined valid flag leave the block through one register stage.

Top module: `ovl_key_mixer`

## Requirements
- R1: After reset, out_vld, out_pix and cfg_err are all 0, and the mode is none.
- R2: A pixel hits the key when, for every channel c whose mask bit kmask[c] is 1, the channel value satisfies kmin_c <= value <= kmax_c (both limits inclusive). Channel c occupies bits [8c+7:8c], so mask bit 0 selects bits 7:0 and mask bit 2 selects bits 23:16. Channels with a clear mask bit are not looked at.
- R3: When the mask is 3'b000, every pixel hits the key.
- R4: In mode none, the output pixel is the overlay pixel, whatever the key registers hold.
- R5: In source mode, an overlay pixel that hits the key is replaced by the underlying pixel. An overlay pixel that misses the key is output unchanged.
- R6: In destination mode, the overlay pixel is output where the underlying pixel hits the key. Everywhere else the underlying pixel is output.
- R7: cfg_req uses bit 0 to request source keying and bit 1 to request destination keying, so 2'b00 means none. A write with cfg_req = 2'b11 is rejected: the mode and the key registers keep their values, and cfg_err is 1 for exactly the one cycle after the write edge. cfg_err is 0 after any accepted write.
- R8: With parameter NO_DST = 1, a write with cfg_req = 2'b10 is rejected in the same way as in R7.
- R9: The key registers load only on an accepted write that requests source or destination keying. A write requesting none, and any rejected write, leaves them unchanged.
- R10: The output is registered with one cycle of latency. A write takes effect for pixels presented from the next cycle on. out_vld equals ovl_vld AND base_vld from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_req | input | 2 | Requested mode: bit 0 source, bit 1 destination |
| cfg_kmin | input | 24 | Key lower bounds, one per channel |
| cfg_kmax | input | 24 | Key upper bounds, one per channel |
| cfg_kmask | input | 3 | Channel enable mask for the key |
| ovl_pix | input | 24 | Overlay pixel |
| ovl_vld | input | 1 | Overlay pixel valid |
| base_pix | input | 24 | Underlying-plane pixel |
| base_vld | input | 1 | Underlying pixel valid |
| out_pix | output | 24 | Selected pixel |
| out_vld | output | 1 | Output valid |
| cfg_err | output | 1 | Rejected-write pulse |

## Verification
Every pixel result, meaning both out_pix and out_vld, appears one clock edge after the pixel is driven. A configuration write changes the mode and keys at its own edge. cfg_err therefore rises at that same edge, and it governs pixels driven on the following cycle.

The bench drives inputs on the falling edge and samples on the next falling edge, so each result is read exactly one rising edge after its stimulus. A bench-side model tracks both instances, one of them built without destination keying. For every mode and mask it sweeps pixels set just below, on, inside and just above each channel's window.

// File: rtl/okm_pkg.sv
package okm_pkg;
  typedef enum logic [1:0] {
    KM_NONE = 2'b00,
    KM_SRC  = 2'b01,
    KM_DST  = 2'b10
  } key_mode_e;

  // A mode request is legal unless both kinds are asked for, or destination
  // keying is asked for in a build that lacks it.
  function automatic logic req_legal(input logic [1:0] req, input logic no_dst);
    logic ok;
    ok = (req != 2'b11);
    if (no_dst && (req == 2'b10)) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/okm_cfg.sv
module okm_cfg import okm_pkg::*; #(
  parameter int PIX_W  = 24,
  parameter int NCH    = 3,
  parameter bit NO_DST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       req,
  input  logic [PIX_W-1:0] kmin_in,
  input  logic [PIX_W-1:0] kmax_in,
  input  logic [NCH-1:0]   kmask_in,
  output key_mode_e        mode_q,
  output logic [PIX_W-1:0] kmin_q,
  output logic [PIX_W-1:0] kmax_q,
  output logic [NCH-1:0]   kmask_q,
  output logic             err_q,
  output logic             wr_reject,
  output logic             wr_load
);
  logic wr_accept;

  assign wr_reject = we && !req_legal(req, NO_DST);
  assign wr_accept = we && !wr_reject;
  assign wr_load   = wr_accept && (req != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= KM_NONE;
      kmin_q  <= '0;
      kmax_q  <= '0;
      kmask_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wr_reject;
      if (wr_accept) mode_q <= key_mode_e'(req);
      if (wr_load) begin
        kmin_q  <= kmin_in;
        kmax_q  <= kmax_in;
        kmask_q <= kmask_in;
      end
    end
  end
endmodule

// File: rtl/okm_match.sv
module okm_match #(
  parameter int CH_W = 8,
  parameter int NCH  = 3,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] kmin,
  input  logic [PIX_W-1:0] kmax,
  input  logic [NCH-1:0]   kmask,
  output logic             hit
);
  function automatic logic in_window(input logic [CH_W-1:0] v,
                                     input logic [CH_W-1:0] lo,
                                     input logic [CH_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  logic [NCH-1:0] ch_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_ok[c] = !kmask[c] ||
                      in_window(pix[c*CH_W +: CH_W], kmin[c*CH_W +: CH_W], kmax[c*CH_W +: CH_W]);
  end

  assign hit = &ch_ok;
endmodule

// File: rtl/okm_select.sv
module okm_select import okm_pkg::*; #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  key_mode_e        mode,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             ovl_vld,
  input  logic [PIX_W-1:0] base_pix,
  input  logic             base_vld,
  input  logic             ovl_hit,
  input  logic             base_hit,
  output logic             use_base,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_vld
);
  always_comb begin
    unique case (mode)
      KM_SRC:  use_base = ovl_hit;
      KM_DST:  use_base = !base_hit;
      default: use_base = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;
      out_vld <= 1'b0;
    end else begin
      out_pix <= use_base ? base_pix : ovl_pix;
      out_vld <= ovl_vld && base_vld;
    end
  end
endmodule

// File: rtl/ovl_key_mixer.sv
module ovl_key_mixer import okm_pkg::*; #(
  parameter int CH_W   = 8,
  parameter int NCH    = 3,
  parameter bit NO_DST = 1'b0,
  localparam int PIX_W = CH_W * NCH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_req,
  input  logic [PIX_W-1:0] cfg_kmin,
  input  logic [PIX_W-1:0] cfg_kmax,
  input  logic [NCH-1:0]   cfg_kmask,
  input  logic [PIX_W-1:0] ovl_pix,
  input  logic             ovl_vld,
  input  logic [PIX_W-1:0] base_pix,
  input  logic             base_vld,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_vld,
  output logic             cfg_err
);
  key_mode_e        mode_q;
  logic [PIX_W-1:0] kmin_q, kmax_q;
  logic [NCH-1:0]   kmask_q;
  logic             wr_reject, wr_load;
  logic             ovl_hit, base_hit, use_base;

  okm_cfg #(.PIX_W(PIX_W), .NCH(NCH), .NO_DST(NO_DST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .req(cfg_req),
    .kmin_in(cfg_kmin), .kmax_in(cfg_kmax), .kmask_in(cfg_kmask),
    .mode_q(mode_q), .kmin_q(kmin_q), .kmax_q(kmax_q), .kmask_q(kmask_q),
    .err_q(cfg_err), .wr_reject(wr_reject), .wr_load(wr_load)
  );

  okm_match #(.CH_W(CH_W), .NCH(NCH)) u_match_ovl (
    .pix(ovl_pix), .kmin(kmin_q), .kmax(kmax_q), .kmask(kmask_q), .hit(ovl_hit)
  );

  okm_match #(.CH_W(CH_W), .NCH(NCH)) u_match_base (
    .pix(base_pix), .kmin(kmin_q), .kmax(kmax_q), .kmask(kmask_q), .hit(base_hit)
  );

  okm_select #(.PIX_W(PIX_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode_q),
    .ovl_pix(ovl_pix), .ovl_vld(ovl_vld), .base_pix(base_pix), .base_vld(base_vld),
    .ovl_hit(ovl_hit), .base_hit(base_hit), .use_base(use_base),
    .out_pix(out_pix), .out_vld(out_vld)
  );
endmodule

// File: rtl/okm_checker.sv
module okm_checker import okm_pkg::*; #(
  parameter int PIX_W  = 24,
  parameter int NCH    = 3,
  parameter bit NO_DST = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [1:0]       cfg_req,
  input logic [PIX_W-1:0] ovl_pix,
  input logic             ovl_vld,
  input logic [PIX_W-1:0] base_pix,
  input logic             base_vld,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_vld,
  input logic             cfg_err,
  input key_mode_e        mode_q,
  input logic [PIX_W-1:0] kmin_q,
  input logic [PIX_W-1:0] kmax_q,
  input logic [NCH-1:0]   kmask_q,
  input logic             ovl_hit
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_VALID_AND: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_vld == $past(ovl_vld && base_vld))); // R10

  AST_NONE_OVERLAY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_q == KM_NONE)) |-> (out_pix == $past(ovl_pix))); // R4

  AST_SRC_PUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(mode_q == KM_SRC && ovl_hit)) |-> (out_pix == $past(base_pix))); // R5

  AST_BOTH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_req == 2'b11) |=> (cfg_err && $stable(mode_q) && $stable(kmin_q) && $stable(kmax_q) && $stable(kmask_q))); // R7

  AST_DST_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (NO_DST && cfg_we && cfg_req == 2'b10) |=> (cfg_err && mode_q != KM_DST)); // R8

  AST_NONE_KEEPS_KEYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_req == 2'b00) |=> (mode_q == KM_NONE && $stable(kmin_q) && $stable(kmax_q) && $stable(kmask_q))); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (past_ok && $past(cfg_we))); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != 2'b11); // R7
endmodule

bind ovl_key_mixer okm_checker #(.PIX_W(PIX_W), .NCH(NCH), .NO_DST(NO_DST)) u_okm_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_req(cfg_req),
  .ovl_pix(ovl_pix), .ovl_vld(ovl_vld), .base_pix(base_pix), .base_vld(base_vld),
  .out_pix(out_pix), .out_vld(out_vld), .cfg_err(cfg_err),
  .mode_q(mode_q), .kmin_q(kmin_q), .kmax_q(kmax_q), .kmask_q(kmask_q),
  .ovl_hit(ovl_hit)
);

// File: tb/test_ovl_key_mixer.sv
`timescale 1ns/1ps
module test_ovl_key_mixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_req = 2'b00;
  logic [23:0] cfg_kmin = '0, cfg_kmax = '0;
  logic [2:0]  cfg_kmask = '0;
  logic [23:0] ovl_pix = '0, base_pix = '0;
  logic        ovl_vld = 1'b0, base_vld = 1'b0;
  logic [23:0] out_pix [2];
  logic        out_vld [2];
  logic        cfg_err [2];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state per instance: 0 = full build, 1 = build without destination keying
  logic [1:0]  m_mode [2];
  logic [23:0] m_min [2], m_max [2];
  logic [2:0]  m_mask [2];

  always #2.5 clk = ~clk;

  ovl_key_mixer i_ovl_key_mixer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_req(cfg_req),
    .cfg_kmin(cfg_kmin), .cfg_kmax(cfg_kmax), .cfg_kmask(cfg_kmask),
    .ovl_pix(ovl_pix), .ovl_vld(ovl_vld), .base_pix(base_pix), .base_vld(base_vld),
    .out_pix(out_pix[0]), .out_vld(out_vld[0]), .cfg_err(cfg_err[0])
  );

  ovl_key_mixer #(.NO_DST(1'b1)) i_ovl_key_mixer_nodst (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_req(cfg_req),
    .cfg_kmin(cfg_kmin), .cfg_kmax(cfg_kmax), .cfg_kmask(cfg_kmask),
    .ovl_pix(ovl_pix), .ovl_vld(ovl_vld), .base_pix(base_pix), .base_vld(base_vld),
    .out_pix(out_pix[1]), .out_vld(out_vld[1]), .cfg_err(cfg_err[1])
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Window test written as arithmetic on integer channel values.
  function automatic bit m_hit(input logic [23:0] p, input logic [23:0] lo,
                               input logic [23:0] hi, input logic [2:0] m);
    bit r = 1'b1;
    for (int c = 0; c < 3; c++) begin
      int v, l, h;
      v = int'((p >> (8 * c)) & 24'hFF);
      l = int'((lo >> (8 * c)) & 24'hFF);
      h = int'((hi >> (8 * c)) & 24'hFF);
      if (m[c] && (v < l || v > h)) r = 1'b0;
    end
    return r;
  endfunction

  task automatic cfg_write(input logic [1:0] req, input logic [23:0] lo,
                           input logic [23:0] hi, input logic [2:0] m);
    bit exp_err [2];
    @(negedge clk);
    cfg_we = 1'b1; cfg_req = req; cfg_kmin = lo; cfg_kmax = hi; cfg_kmask = m;
    for (int i = 0; i < 2; i++) begin
      bit legal;
      legal = (req != 2'b11) && !(i == 1 && req == 2'b10);
      exp_err[i] = !legal;
      if (legal) begin
        m_mode[i] = req;
        if (req != 2'b00) begin
          m_min[i] = lo; m_max[i] = hi; m_mask[i] = m;
        end
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    for (int i = 0; i < 2; i++) check((i == 1) ? "R7/R8 cfg_err" : "R7 cfg_err",
                                       32'(cfg_err[i]), 32'(exp_err[i]));
  endtask

  task automatic pix(input string tag, input logic [23:0] o, input logic [23:0] b,
                     input logic vo, input logic vb);
    @(negedge clk);
    ovl_pix = o; base_pix = b; ovl_vld = vo; base_vld = vb;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      logic [23:0] e;
      case (m_mode[i])
        2'b01:   e = m_hit(o, m_min[i], m_max[i], m_mask[i]) ? b : o;
        2'b10:   e = m_hit(b, m_min[i], m_max[i], m_mask[i]) ? o : b;
        default: e = o;
      endcase
      check(tag, 32'(out_pix[i]), 32'(e));
      check("R10 out_vld", 32'(out_vld[i]), 32'(vo & vb));
    end
  endtask

  localparam logic [23:0] KMIN = 24'h604020;
  localparam logic [23:0] KMAX = 24'h705030;

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_mode[i] = 2'b00; m_min[i] = '0; m_max[i] = '0; m_mask[i] = '0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      check("R1 out_vld", 32'(out_vld[i]), 32'd0);
      check("R1 out_pix", 32'(out_pix[i]), 32'd0);
      check("R1 cfg_err", 32'(cfg_err[i]), 32'd0);
    end
    rst_n = 1'b1;
    // R1: mode none after reset, overlay passes
    pix("R1 mode none", 24'h123456, 24'h654321, 1'b1, 1'b1);

    // Sweep every mode and mask over pixels around each channel window.
    for (int md = 0; md < 3; md++) begin
      for (int mk = 0; mk < 8; mk++) begin
        cfg_write(2'(md), KMIN, KMAX, 3'(mk));
        for (int k = 0; k < 125; k++) begin
          logic [23:0] p, other;
          string tag;
          int sel [3];
          sel[0] = k % 5; sel[1] = (k / 5) % 5; sel[2] = k / 25;
          p = '0;
          for (int c = 0; c < 3; c++) begin
            int l, h, v;
            l = int'((KMIN >> (8 * c)) & 24'hFF);
            h = int'((KMAX >> (8 * c)) & 24'hFF);
            case (sel[c])
              0: v = l - 1;
              1: v = l;
              2: v = (l + h) / 2;
              3: v = h;
              default: v = h + 1;
            endcase
            p = p | (24'(v) << (8 * c));
          end
          other = 24'hA5C3E1 ^ 24'(k);
          if (mk == 0)      tag = "R3 mask zero";
          else if (md == 0) tag = "R4 none";
          else if (md == 1) tag = "R2/R5 source";
          else              tag = "R2/R6 dest R8";
          if (md == 2) pix(tag, other, p, (k % 3) != 0, (k % 4) != 0);
          else         pix(tag, p, other, (k % 3) != 0, (k % 4) != 0);
        end
      end
    end

    // R7: both kinds requested while in source mode, keys must stay.
    cfg_write(2'b01, KMIN, KMAX, 3'b111);
    cfg_write(2'b11, 24'h000000, 24'h000000, 3'b111);
    @(negedge clk);
    for (int i = 0; i < 2; i++) check("R7 err one cycle", 32'(cfg_err[i]), 32'd0);
    pix("R7 mode kept", 24'h654525, 24'h111111, 1'b1, 1'b1);
    pix("R9 keys kept after reject", 24'h000000, 24'h222222, 1'b1, 1'b1);

    // R8: destination request on both builds; the reduced one stays in source mode.
    cfg_write(2'b10, 24'h000000, 24'h0F0F0F, 3'b111);
    pix("R8 dest probe", 24'h101010, 24'h050505, 1'b1, 1'b1);
    pix("R8 R9 old key", 24'h654525, 24'h333333, 1'b1, 1'b1);

    // R9: a none write carries other keys; overlay shown, then source reload uses fresh keys.
    cfg_write(2'b00, 24'hFFFFFF, 24'hFFFFFF, 3'b000);
    pix("R9 none after write", 24'h654525, 24'h444444, 1'b1, 1'b1);
    cfg_write(2'b01, KMIN, KMAX, 3'b001);
    pix("R9 source reload", 24'h000025, 24'h555555, 1'b1, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule